// File: doc/BRIEF.md
# Bfloat16 Adder-Subtractor

The block adds or subtracts two bfloat16 numbers. Each operand has one sign bit (bit 15), an 8-bit biased exponent (bits 14:7) and a 7-bit fraction (bits 6:0). The result uses the same format.

Operands arrive on a valid/ready stream together with a subtract flag. Results leave on a second valid/ready stream, in the order the operands were accepted. A subtraction is handled as an addition with the sign of the second operand inverted.

Special operands are resolved before any arithmetic. Otherwise the exponents are aligned and the magnitudes are added or subtracted. A leading-one count renormalises the result, which is then repacked. Bits shifted out during alignment are dropped, with no rounding. Subnormal operands take part without a hidden one.

Inside the block, one register stage holds the operands and one holds the result. An accepted operand pair therefore appears at the output after two clock edges, provided the output is not stalled.

Back-pressure rules:
- The input side takes a pair on any edge where `in_valid` and `in_ready` are both high.
- `in_ready` is low only when both stages are full and the consumer holds `out_ready` low.
- `out_sum` must not change while `out_valid` is high and `out_ready` is low.

Top module: `bf16_addsub`

## Requirements
- R1: An operand is a NaN when its exponent field is 0xFF and its fraction is nonzero. If A is a NaN, the result is A unchanged. Otherwise, if B is a NaN, the result is B unchanged.
- R2: An infinity has exponent 0xFF and fraction 0. Two infinities of opposite sign give 0xFFC0. Two infinities of the same sign give B. An infinity combined with a finite operand gives the infinite operand.
- R3: If A is ±0 (bits 14:0 all zero), the result is B. If B is ±0 and A is finite and nonzero, the result is A.
- R4: With `in_sub` = 1, bit 15 of B is inverted before any other step. This also applies when B is returned as is.
- R5: The hidden bit (value 0x80 on the 8-bit significand) is present only when the exponent is nonzero. If the exponents differ by 8 or more, the operand with the larger exponent is returned. Otherwise the significand with the smaller exponent is shifted right by the difference, and the bits shifted out are discarded.
- R6: When the effective signs match, the significands are added. A carry into bit 8 shifts the sum right by one and raises the exponent by one. An exponent of 255 or more yields an infinity with the common sign (sign | 0x7F80).
- R7: When the effective signs differ, the smaller significand is subtracted from the larger. The result takes the sign of the larger one. A zero difference gives 0x0000.
- R8: A nonzero difference is shifted left until bit 7 is set, and the exponent is lowered once per shift. If the exponent would reach 0 or less, the result is 0x0000. A difference whose bit 7 is already set is left as it is.
- R9: A pair is accepted on an edge with `in_valid` and `in_ready` high. Its result appears on `out_sum`, with `out_valid` high, after the next edge if the output is not stalled. Results leave in acceptance order.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_sum` hold their values. `in_ready` falls once both stages are occupied.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | 16 | Operand A, bfloat16 |
| in_b | input | 16 | Operand B, bfloat16 |
| in_sub | input | 1 | 1 computes A - B, 0 computes A + B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_sum | output | 16 | Result, bfloat16 |

## Verification
The hardest cases to reach are the two underflow paths.

The first is a difference that has to be renormalised past the bottom of the exponent range. Reaching it needs nearly equal operands of opposite sign whose exponents are tiny. The stimulus uses 0x0100 plus 0x80FF: after the one-place alignment truncates, the difference is 1. It also uses a subnormal pair whose exponent is already 0.

The second is that the outcome at an exponent gap of exactly 8 must not depend on which operand holds the larger exponent. The stimulus tries both operand orders.

Stalls are produced by holding `out_ready` low while two pairs are pushed in. The held output is then watched for several cycles before release.

// File: rtl/bf16_addsub_pkg.sv
package bf16_addsub_pkg;
  localparam int BF_EXP_W = 8;
  localparam int BF_MAN_W = 7;

  // Source of the value loaded into the result register
  typedef enum logic [1:0] {
    SEL_SPECIAL = 2'd0,
    SEL_GAP     = 2'd1,
    SEL_ARITH   = 2'd2
  } res_sel_e;
endpackage

// File: rtl/bf16_special.sv
module bf16_special #(
  parameter int EXP_W = bf16_addsub_pkg::BF_EXP_W,
  parameter int MAN_W = bf16_addsub_pkg::BF_MAN_W,
  parameter int W     = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         take,
  output logic [W-1:0] val
);
  localparam logic [EXP_W-1:0] EMAX = '1;
  localparam logic [W-1:0] NEG_QNAN = {1'b1, EMAX, 1'b1, {(MAN_W-1){1'b0}}};

  logic             a_s, b_s;
  logic [EXP_W-1:0] a_e, b_e;
  logic [MAN_W-1:0] a_m, b_m;

  assign a_s = opa[W-1];
  assign b_s = opb[W-1];
  assign a_e = opa[W-2:MAN_W];
  assign b_e = opb[W-2:MAN_W];
  assign a_m = opa[MAN_W-1:0];
  assign b_m = opb[MAN_W-1:0];

  // Priority: A all-ones exponent, B all-ones exponent, A zero, B zero
  always_comb begin
    take = 1'b1;
    val  = opa;
    if (a_e == EMAX) begin
      if (a_m != '0)       val = opa;
      else if (b_e == EMAX) begin
        if (b_m != '0)     val = opb;
        else if (a_s == b_s) val = opb;
        else               val = NEG_QNAN;
      end else             val = opa;
    end else if (b_e == EMAX) begin
      val = opb;
    end else if (a_e == '0 && a_m == '0) begin
      val = opb;
    end else if (b_e == '0 && b_m == '0) begin
      val = opa;
    end else begin
      take = 1'b0;
    end
  end
endmodule

// File: rtl/bf16_align_mag.sv
module bf16_align_mag #(
  parameter int EXP_W = bf16_addsub_pkg::BF_EXP_W,
  parameter int MAN_W = bf16_addsub_pkg::BF_MAN_W,
  parameter int W     = 1 + EXP_W + MAN_W,
  parameter int SIG_W = MAN_W + 1
) (
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  output logic             gap_pass,
  output logic [W-1:0]     gap_val,
  output logic             eff_sub,
  output logic             res_sign,
  output logic [EXP_W-1:0] big_e,
  output logic [SIG_W:0]   mag
);
  logic             a_s, b_s;
  logic [EXP_W-1:0] a_e, b_e, gap;
  logic [SIG_W-1:0] sig_a, sig_b, al_a, al_b;

  assign a_s   = opa[W-1];
  assign b_s   = opb[W-1];
  assign a_e   = opa[W-2:MAN_W];
  assign b_e   = opb[W-2:MAN_W];
  // hidden one only for a nonzero exponent
  assign sig_a = {a_e != '0, opa[MAN_W-1:0]};
  assign sig_b = {b_e != '0, opb[MAN_W-1:0]};
  assign eff_sub = a_s ^ b_s;

  always_comb begin
    if (a_e >= b_e) begin
      gap     = a_e - b_e;
      big_e   = a_e;
      al_a    = sig_a;
      al_b    = sig_b >> gap;
      gap_val = opa;
    end else begin
      gap     = b_e - a_e;
      big_e   = b_e;
      al_a    = sig_a >> gap;
      al_b    = sig_b;
      gap_val = opb;
    end
    gap_pass = (gap >= EXP_W'(SIG_W));
  end

  always_comb begin
    if (!eff_sub) begin
      mag      = {1'b0, al_a} + {1'b0, al_b};
      res_sign = a_s;
    end else if (al_a >= al_b) begin
      mag      = {1'b0, al_a} - {1'b0, al_b};
      res_sign = a_s;
    end else begin
      mag      = {1'b0, al_b} - {1'b0, al_a};
      res_sign = b_s;
    end
  end
endmodule

// File: rtl/bf16_lzd.sv
module bf16_lzd #(
  parameter int N  = bf16_addsub_pkg::BF_MAN_W + 1,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] zeros
);
  // Scan upward; the highest set bit is the last one written
  always_comb begin
    zeros = CW'(N);
    for (int i = 0; i < N; i++) begin
      if (vec[i]) zeros = CW'(N - 1 - i);
    end
  end
endmodule

// File: rtl/bf16_norm_pack.sv
module bf16_norm_pack #(
  parameter int EXP_W = bf16_addsub_pkg::BF_EXP_W,
  parameter int MAN_W = bf16_addsub_pkg::BF_MAN_W,
  parameter int W     = 1 + EXP_W + MAN_W,
  parameter int SIG_W = MAN_W + 1
) (
  input  logic             eff_sub,
  input  logic             sign,
  input  logic [EXP_W-1:0] big_e,
  input  logic [SIG_W:0]   mag,
  output logic [W-1:0]     res
);
  localparam int CW = $clog2(SIG_W + 1);
  localparam logic [EXP_W-1:0] EMAX = '1;

  logic [CW-1:0]    lz;
  logic [EXP_W:0]   e_inc, lz_ext;
  logic [SIG_W-1:0] shl;

  bf16_lzd #(.N(SIG_W), .CW(CW)) u_lzd (
    .vec   (mag[SIG_W-1:0]),
    .zeros (lz)
  );

  assign e_inc  = {1'b0, big_e} + 1'b1;
  assign lz_ext = (EXP_W+1)'(lz);
  assign shl    = mag[SIG_W-1:0] << lz;

  always_comb begin
    if (!eff_sub) begin
      if (mag[SIG_W]) begin
        if (e_inc >= {1'b0, EMAX}) res = {sign, EMAX, {MAN_W{1'b0}}};
        else                       res = {sign, e_inc[EXP_W-1:0], mag[SIG_W-1:1]};
      end else begin
        res = {sign, big_e, mag[MAN_W-1:0]};
      end
    end else if (mag == '0) begin
      res = '0;
    end else if (lz == '0) begin
      res = {sign, big_e, mag[MAN_W-1:0]};
    end else if ({1'b0, big_e} <= lz_ext) begin
      res = '0;
    end else begin
      res = {sign, big_e - lz_ext[EXP_W-1:0], shl[MAN_W-1:0]};
    end
  end
endmodule

// File: rtl/bf16_addsub.sv
module bf16_addsub
  import bf16_addsub_pkg::*;
#(
  parameter int EXP_W = BF_EXP_W,
  parameter int MAN_W = BF_MAN_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [EXP_W+MAN_W:0]     in_a,
  input  logic [EXP_W+MAN_W:0]     in_b,
  input  logic                     in_sub,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [EXP_W+MAN_W:0]     out_sum
);
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int SIG_W = MAN_W + 1;
  localparam logic [EXP_W-1:0] EMAX = '1;
  localparam logic [W-1:0] NEG_QNAN = {1'b1, EMAX, 1'b1, {(MAN_W-1){1'b0}}};

  logic             s1_v;
  logic [W-1:0]     s1_a, s1_b;
  logic             s1_free, s2_free;

  logic             sp_take, gap_pass, eff_sub, res_sign;
  logic [W-1:0]     sp_val, gap_val, norm_res, res;
  logic [EXP_W-1:0] big_e;
  logic [SIG_W:0]   mag;
  res_sel_e         sel;

  assign s2_free  = !out_valid || out_ready;
  assign s1_free  = !s1_v || s2_free;
  assign in_ready = s1_free;

  // Operand stage; subtraction inverts the sign of B on capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_a <= '0;
      s1_b <= '0;
    end else if (s1_free) begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_a <= in_a;
        s1_b <= {in_b[W-1] ^ in_sub, in_b[W-2:0]};
      end
    end
  end

  bf16_special #(.EXP_W(EXP_W), .MAN_W(MAN_W), .W(W)) u_special (
    .opa (s1_a), .opb (s1_b), .take (sp_take), .val (sp_val)
  );

  bf16_align_mag #(.EXP_W(EXP_W), .MAN_W(MAN_W), .W(W), .SIG_W(SIG_W)) u_align (
    .opa (s1_a), .opb (s1_b), .gap_pass (gap_pass), .gap_val (gap_val),
    .eff_sub (eff_sub), .res_sign (res_sign), .big_e (big_e), .mag (mag)
  );

  bf16_norm_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .W(W), .SIG_W(SIG_W)) u_norm (
    .eff_sub (eff_sub), .sign (res_sign), .big_e (big_e), .mag (mag), .res (norm_res)
  );

  always_comb begin
    if (sp_take)       sel = SEL_SPECIAL;
    else if (gap_pass) sel = SEL_GAP;
    else               sel = SEL_ARITH;
    case (sel)
      SEL_SPECIAL: res = sp_val;
      SEL_GAP:     res = gap_val;
      default:     res = norm_res;
    endcase
  end

  // Result stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else if (s2_free) begin
      out_valid <= s1_v;
      if (s1_v) out_sum <= res;
    end
  end

  // R10: stalled output is held
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sum));

  // R1: NaN in A reaches the output untouched
  p_nan_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && s2_free && s1_a[W-2:MAN_W] == EMAX && s1_a[MAN_W-1:0] != '0
    |=> out_sum == $past(s1_a));

  // R2: opposite infinities give the fixed negative quiet NaN
  p_inf_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && s2_free && s1_a[W-2:0] == {EMAX, {MAN_W{1'b0}}}
    && s1_b[W-2:0] == {EMAX, {MAN_W{1'b0}}} && (s1_a[W-1] != s1_b[W-1])
    |=> out_sum == NEG_QNAN);

  // R3: zero A passes B through
  p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && s2_free && s1_a[W-2:0] == '0 |=> out_sum == $past(s1_b));

  // R8: a renormalised difference always lowers the exponent
  p_norm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v && sel == SEL_ARITH && eff_sub && mag != '0 && !mag[SIG_W-1]
    && norm_res != '0 |-> norm_res[W-2:MAN_W] < big_e);
endmodule

// File: tb/bf16_addsub_bench.sv
`timescale 1ns/1ps
module bf16_addsub_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_a = '0, in_b = '0;
  logic        in_sub = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_sum;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  bf16_addsub u_bf16_addsub (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_a (in_a), .in_b (in_b), .in_sub (in_sub), .out_valid (out_valid),
    .out_ready (out_ready), .out_sum (out_sum)
  );

  typedef struct packed {
    logic        sub;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h3F80, 16'h4000, 16'h4040, 8'd5},  // R5 1+2 with one-place align
    '{1'b1, 16'h4000, 16'h3F80, 16'h3F80, 8'd4},  // R4 2-1
    '{1'b1, 16'h3F80, 16'h4000, 16'hBF80, 8'd4},  // R4 1-2
    '{1'b0, 16'h3F80, 16'h3F80, 16'h4000, 8'd6},  // R6 carry
    '{1'b0, 16'h7FC1, 16'h3F80, 16'h7FC1, 8'd1},  // R1 A NaN
    '{1'b0, 16'h3F80, 16'hFF81, 16'hFF81, 8'd1},  // R1 B NaN
    '{1'b0, 16'h7FC1, 16'h7FC2, 16'h7FC1, 8'd1},  // R1 A first
    '{1'b0, 16'h7F80, 16'h7FC2, 16'h7FC2, 8'd1},  // R1 inf A, NaN B
    '{1'b0, 16'h7F80, 16'hFF80, 16'hFFC0, 8'd2},  // R2 +inf + -inf
    '{1'b1, 16'h7F80, 16'h7F80, 16'hFFC0, 8'd2},  // R2 inf - inf
    '{1'b0, 16'hFF80, 16'hFF80, 16'hFF80, 8'd2},  // R2 same sign
    '{1'b0, 16'h7F80, 16'h3F80, 16'h7F80, 8'd2},  // R2 inf A
    '{1'b0, 16'h3F80, 16'hFF80, 16'hFF80, 8'd2},  // R2 inf B
    '{1'b0, 16'h0000, 16'hC120, 16'hC120, 8'd3},  // R3 zero A
    '{1'b0, 16'hC120, 16'h8000, 16'hC120, 8'd3},  // R3 zero B
    '{1'b1, 16'h0000, 16'h3F80, 16'hBF80, 8'd3},  // R3 with flipped B
    '{1'b0, 16'h4380, 16'h3F80, 16'h4380, 8'd5},  // R5 gap 8, A larger
    '{1'b0, 16'h3F80, 16'h4380, 16'h4380, 8'd5},  // R5 gap 8, B larger
    '{1'b0, 16'h4380, 16'h3B80, 16'h4380, 8'd5},  // R5 gap 16
    '{1'b0, 16'h4300, 16'h3F80, 16'h4301, 8'd5},  // R5 gap 7 truncation
    '{1'b0, 16'h0001, 16'h0001, 16'h0002, 8'd5},  // R5 subnormal, no hidden one
    '{1'b0, 16'h7F7F, 16'h7F7F, 16'h7F80, 8'd6},  // R6 overflow +
    '{1'b0, 16'hFF7F, 16'hFF7F, 16'hFF80, 8'd6},  // R6 overflow -
    '{1'b1, 16'h3F80, 16'h3F80, 16'h0000, 8'd7},  // R7 exact cancel
    '{1'b0, 16'hBF80, 16'h3F80, 16'h0000, 8'd7},  // R7 cancel gives +0
    '{1'b0, 16'h3F80, 16'hC000, 16'hBF80, 8'd7},  // R7 sign of larger
    '{1'b0, 16'h4000, 16'hBFFF, 16'h3C80, 8'd8},  // R8 shift by 7
    '{1'b0, 16'h0100, 16'h80FF, 16'h0000, 8'd8},  // R8 flush
    '{1'b1, 16'h0003, 16'h0001, 16'h0000, 8'd8}   // R8 flush at exp 0
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic s, input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] exp, input int rq);
    @(negedge clk);
    in_sub = s; in_a = a; in_b = b; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check($sformatf("R%0d out_valid (R9)", rq), {15'd0, out_valid}, 16'd1);
    check($sformatf("R%0d %h%s%h", rq, a, s ? "-" : "+", b), out_sum, exp);
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 out_valid after reset", {15'd0, out_valid}, 16'd0);
    check("R11 in_ready after reset", {15'd0, in_ready}, 16'd1);

    for (int i = 0; i < NV; i++)
      run_op(VECS[i].sub, VECS[i].a, VECS[i].b, VECS[i].exp, int'(VECS[i].req));

    // R9 R10 back-pressure with two pairs in flight
    @(negedge clk);
    out_ready = 1'b0;
    in_sub = 1'b0; in_a = 16'h3F80; in_b = 16'h4000; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_a = 16'h7F7F; in_b = 16'h7F7F;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 in_ready low when full", {15'd0, in_ready}, 16'd0);
    check("R9 first result present", {15'd0, out_valid}, 16'd1);
    check("R9 first result value", out_sum, 16'h4040);
    repeat (3) @(negedge clk);
    check("R10 held valid", {15'd0, out_valid}, 16'd1);
    check("R10 held value", out_sum, 16'h4040);
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 second result in order", out_sum, 16'h7F80);
    check("R9 second result valid", {15'd0, out_valid}, 16'd1);
    @(negedge clk);
    check("R9 drained", {15'd0, out_valid}, 16'd0);
    check("R10 in_ready restored", {15'd0, in_ready}, 16'd1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule